// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the software-facing front end of an eight-line interrupt controller. It sits on a two-address byte bus and turns each write into one of three things: the start of an initialization sequence, a word inside that sequence, or an operation command. It holds the controller's configuration: line mask, vector base, automatic end-of-interrupt, special fully nested mode, rotation base, read selection, poll mode and special mask. It also holds a per-line trigger-mode register, written through its own strobe. The register forces some lines to edge mode with a per-instance constant.

The request and in-service registers themselves live in the priority core outside this block. The core feeds them in so that they can be read back and so that end-of-interrupt commands can find their target. This block answers with one-cycle clear pulses for in-service and request bits, and a new rotation base. In poll mode a read returns the number that the external resolver supplies and clears that line.

Top module: `pic_regif`

## Requirements
- R1: After reset, and in the cycle after any write at address 0 with data bit 4 set, the mask, vector base, auto-EOI, nested mode, rotation base, rotate-on-auto-EOI, read select, poll, special mask and trigger-mode outputs are all zero. A start write additionally pulses every bit of `insvc_clr` and `req_clr` for one cycle. Data bits 1 and 3 of that start word have no effect.
- R2: After a start write, the next address-1 write stores data AND 0xF8 as the vector base. The following address-1 write is consumed without touching any output. If bit 0 of the start word was 1, one more address-1 write sets nested mode from its bit 4 and auto-EOI from its bit 1. The sequence then returns to normal operation.
- R3: In normal operation, a write at address 1 loads the mask, which reads back at address 1.
- R4: A write at address 0 with bit 4 clear and bit 3 set is a read/poll command. Bit 2 = 1 sets poll mode. If bit 1 = 1, bit 0 sets read select (1 = in-service, 0 = request). If bit 6 = 1, bit 5 sets special mask. Bits that are not enabled leave their flag unchanged.
- R5: With bits 4 and 3 clear, the command code is data[7:5]. Code 0 clears rotate-on-auto-EOI and code 4 sets it.
- R6: Code 1 pulses the `insvc_clr` bit of the highest-priority set in-service line. Priority runs from the rotation base upward, modulo 8. Code 5 does the same and sets the base to that line + 1 (mod 8). Neither command pulses or rotates when no in-service bit is set.
- R7: Code 3 pulses `insvc_clr` bit data[2:0]. Code 6 sets the base to data[2:0] + 1 (mod 8). Code 7 does both. Code 2 changes nothing.
- R8: Outside poll mode, a read at address 0 returns the in-service input when read select is 1 and the request input when it is 0.
- R9: A read at either address while poll mode is set returns the resolver line (0..7) if the resolver reports a pending line, else 7. For a reported line it pulses that line's `insvc_clr` and `req_clr` bits one cycle later. Poll mode is clear after the read.
- R10: A trigger-mode write stores its data AND the per-instance constant (default 0xF8, so lines 0 to 2 stay edge mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data |
| req_vec | input | 8 | Request register from the priority core |
| insvc_vec | input | 8 | In-service register from the priority core |
| poll_valid | input | 1 | Resolver reports a pending line |
| poll_line | input | 3 | Resolver's pending line |
| mask_out | output | 8 | Line mask |
| vec_base | output | 8 | Vector base (low 3 bits zero) |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nested_sfn | output | 1 | Special fully nested mode |
| rot_base | output | 3 | Line that currently has the highest priority |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| read_insvc | output | 1 | Read select: 1 = in-service |
| poll_mode | output | 1 | Poll mode pending |
| spec_mask | output | 1 | Special mask mode |
| trig_mode | output | 8 | Per-line trigger mode (1 = level) |
| insvc_clr | output | 8 | One-cycle in-service clear pulses |
| req_clr | output | 8 | One-cycle request clear pulses |

## Verification
The hardest case is the non-specific end-of-interrupt. Its target depends jointly on the in-service pattern and on a rotation base, and the base can only be reached through earlier rotate commands. The bench therefore loads each of the eight bases with a set-priority command and then drives all 256 in-service patterns under each. It issues both the plain and the rotating form, and it predicts the target by scanning upward from the base. The initialization path is reached through both sequence lengths. Each time, the bench confirms that the skipped word does not land in the mask.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  // Highest-priority set line of vec, searching upward from base (mod LINES).
  function automatic logic [LINE_W-1:0] prio_pick(input logic [LINES-1:0] vec,
                                                  input logic [LINE_W-1:0] base);
    logic [LINE_W-1:0] pick;
    logic [LINE_W-1:0] ln;
    logic found;
    pick  = base;
    found = 1'b0;
    for (int k = 0; k < LINES; k++) begin
      ln = base + LINE_W'(k);
      if (!found && vec[ln]) begin
        pick  = ln;
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  // Line that follows ln in rotation order.
  function automatic logic [LINE_W-1:0] after_line(input logic [LINE_W-1:0] ln);
    return ln + LINE_W'(1);
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_regif_pkg::*;
#(
  parameter logic [DATA_W-1:0] TRIG_KEEP = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig_we,
  input  logic [DATA_W-1:0] trig_wdata,
  output logic              init_go,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] vbase_q,
  output logic              aeoi_q,
  output logic              sfnm_q,
  output logic [DATA_W-1:0] trig_q
);
  localparam logic [DATA_W-1:0] BASE_KEEP = DATA_W'(8'hF8);

  seq_state_e st;
  logic       need_mode;
  logic       data_wr;

  assign init_go = wr & ~addr & wdata[4];
  assign data_wr = wr & addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SEQ_RUN;
      need_mode <= 1'b0;
      mask_q    <= '0;
      vbase_q   <= '0;
      aeoi_q    <= 1'b0;
      sfnm_q    <= 1'b0;
      trig_q    <= '0;
    end else if (init_go) begin
      st        <= SEQ_BASE;
      need_mode <= wdata[0];
      mask_q    <= '0;
      vbase_q   <= '0;
      aeoi_q    <= 1'b0;
      sfnm_q    <= 1'b0;
      trig_q    <= '0;
    end else begin
      if (trig_we) trig_q <= trig_wdata & TRIG_KEEP;
      if (data_wr) begin
        case (st)
          SEQ_RUN:  mask_q <= wdata;
          SEQ_BASE: begin
            vbase_q <= wdata & BASE_KEEP;
            st      <= SEQ_CASC;
          end
          SEQ_CASC: st <= need_mode ? SEQ_MODE : SEQ_RUN;
          SEQ_MODE: begin
            sfnm_q <= wdata[4];
            aeoi_q <= wdata[1];
            st     <= SEQ_RUN;
          end
          default:  st <= SEQ_RUN;
        endcase
      end
    end
  end

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> (st == SEQ_BASE && mask_q == '0 && trig_q == '0 && vbase_q == '0));

  assert_base_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_go && st == SEQ_BASE) |=>
      (vbase_q == ($past(wdata) & BASE_KEEP) && st == SEQ_CASC));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_go && !(data_wr && st == SEQ_RUN)) |=> $stable(mask_q));

  assert_trig_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !init_go) |=> (trig_q == ($past(trig_wdata) & TRIG_KEEP)));
endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
  import pic_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              init_go,
  input  logic [LINES-1:0]  isr_vec,
  input  logic              poll_valid,
  input  logic [LINE_W-1:0] poll_line,
  output logic [LINE_W-1:0] rot_base,
  output logic              rot_aeoi,
  output logic              read_isr,
  output logic              poll_q,
  output logic              smm_q,
  output logic [LINES-1:0]  isr_clr,
  output logic [LINES-1:0]  irr_clr
);
  logic              cmd_wr, ocw3, ocw2, poll_take, isr_any;
  logic [2:0]        code;
  logic [LINE_W-1:0] top_line, arg_line;
  logic [LINES-1:0]  isr_clr_d, irr_clr_d;
  logic [LINE_W-1:0] base_d;

  assign cmd_wr    = wr & ~addr & ~wdata[4];
  assign ocw3      = cmd_wr & wdata[3];
  assign ocw2      = cmd_wr & ~wdata[3];
  assign code      = wdata[7:5];
  assign arg_line  = wdata[LINE_W-1:0];
  assign poll_take = rd & poll_q;
  assign isr_any   = |isr_vec;
  assign top_line  = prio_pick(isr_vec, rot_base);

  always_comb begin
    isr_clr_d = '0;
    irr_clr_d = '0;
    base_d    = rot_base;
    if (init_go) begin
      isr_clr_d = '1;
      irr_clr_d = '1;
      base_d    = '0;
    end else begin
      if (poll_take && poll_valid) begin
        isr_clr_d[poll_line] = 1'b1;
        irr_clr_d[poll_line] = 1'b1;
      end
      if (ocw2) begin
        case (code)
          3'd1, 3'd5: if (isr_any) begin
            isr_clr_d[top_line] = 1'b1;
            if (code[2]) base_d = after_line(top_line);
          end
          3'd3: isr_clr_d[arg_line] = 1'b1;
          3'd6: base_d = after_line(arg_line);
          3'd7: begin
            isr_clr_d[arg_line] = 1'b1;
            base_d = after_line(arg_line);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_base <= '0;
      rot_aeoi <= 1'b0;
      read_isr <= 1'b0;
      poll_q   <= 1'b0;
      smm_q    <= 1'b0;
      isr_clr  <= '0;
      irr_clr  <= '0;
    end else begin
      rot_base <= base_d;
      isr_clr  <= isr_clr_d;
      irr_clr  <= irr_clr_d;
      if (init_go) begin
        rot_aeoi <= 1'b0;
        read_isr <= 1'b0;
        poll_q   <= 1'b0;
        smm_q    <= 1'b0;
      end else begin
        if (poll_take) poll_q <= 1'b0;
        if (ocw3) begin
          if (wdata[2]) poll_q   <= 1'b1;
          if (wdata[1]) read_isr <= wdata[0];
          if (wdata[6]) smm_q    <= wdata[5];
        end
        if (ocw2 && code[1:0] == 2'b00) rot_aeoi <= code[2];
      end
    end
  end

  assert_poll_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !ocw3) |=> !poll_q);

  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !init_go |=> $onehot0(isr_clr));

  assert_eoi_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2 && code == 3'd1 && !isr_any && !poll_take && !init_go) |=>
      (isr_clr == '0 && $stable(rot_base)));

  assert_init_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> (isr_clr == '1 && irr_clr == '1 && rot_base == '0 && !poll_q));
endmodule

// File: rtl/pic_read_port.sv
module pic_read_port
  import pic_regif_pkg::*;
(
  input  logic              addr,
  input  logic              poll_q,
  input  logic              poll_valid,
  input  logic [LINE_W-1:0] poll_line,
  input  logic              read_isr,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [LINES-1:0]  isr_vec,
  input  logic [LINES-1:0]  irr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] NONE_CODE = DATA_W'(LINES - 1);

  always_comb begin
    if (poll_q)        rdata = poll_valid ? DATA_W'(poll_line) : NONE_CODE;
    else if (addr)     rdata = mask_q;
    else if (read_isr) rdata = DATA_W'(isr_vec);
    else               rdata = DATA_W'(irr_vec);
  end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_regif_pkg::*;
#(
  parameter logic [7:0] TRIG_KEEP = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       trig_we,
  input  logic [7:0] trig_wdata,
  input  logic [7:0] req_vec,
  input  logic [7:0] insvc_vec,
  input  logic       poll_valid,
  input  logic [2:0] poll_line,
  output logic [7:0] mask_out,
  output logic [7:0] vec_base,
  output logic       auto_eoi,
  output logic       nested_sfn,
  output logic [2:0] rot_base,
  output logic       rot_on_aeoi,
  output logic       read_insvc,
  output logic       poll_mode,
  output logic       spec_mask,
  output logic [7:0] trig_mode,
  output logic [7:0] insvc_clr,
  output logic [7:0] req_clr
);
  logic init_go;

  pic_init_seq #(.TRIG_KEEP(TRIG_KEEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .init_go(init_go),
    .mask_q(mask_out), .vbase_q(vec_base), .aeoi_q(auto_eoi),
    .sfnm_q(nested_sfn), .trig_q(trig_mode)
  );

  pic_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .init_go(init_go), .isr_vec(insvc_vec),
    .poll_valid(poll_valid), .poll_line(poll_line), .rot_base(rot_base),
    .rot_aeoi(rot_on_aeoi), .read_isr(read_insvc), .poll_q(poll_mode),
    .smm_q(spec_mask), .isr_clr(insvc_clr), .irr_clr(req_clr)
  );

  pic_read_port u_rd (
    .addr(bus_addr), .poll_q(poll_mode), .poll_valid(poll_valid),
    .poll_line(poll_line), .read_isr(read_insvc), .mask_q(mask_out),
    .isr_vec(insvc_vec), .irr_vec(req_vec), .rdata(bus_rdata)
  );

  assert_poll_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && poll_mode && !poll_valid) |-> (bus_rdata == 8'h07));

  assert_mask_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !poll_mode && bus_addr) |-> (bus_rdata == mask_out));
endmodule

// File: tb/tb_pic_regif.sv
module tb_pic_regif;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_we = 1'b0;
  logic [7:0] trig_wdata = '0;
  logic [7:0] req_vec = '0, insvc_vec = '0;
  logic       poll_valid = 1'b0;
  logic [2:0] poll_line = '0;
  logic [7:0] mask_out, vec_base, trig_mode, insvc_clr, req_clr;
  logic       auto_eoi, nested_sfn, rot_on_aeoi, read_insvc, poll_mode, spec_mask;
  logic [2:0] rot_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_we(trig_we),
    .trig_wdata(trig_wdata), .req_vec(req_vec), .insvc_vec(insvc_vec),
    .poll_valid(poll_valid), .poll_line(poll_line), .mask_out(mask_out),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .nested_sfn(nested_sfn),
    .rot_base(rot_base), .rot_on_aeoi(rot_on_aeoi), .read_insvc(read_insvc),
    .poll_mode(poll_mode), .spec_mask(spec_mask), .trig_mode(trig_mode),
    .insvc_clr(insvc_clr), .req_clr(req_clr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_bus(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_bus(input logic a, output logic [7:0] got);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 got = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_trig(input logic [7:0] d);
    @(negedge clk);
    trig_wdata = d; trig_we = 1'b1;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  // Expected target of a non-specific end-of-interrupt: scan upward from base.
  function automatic int eoi_target(input logic [7:0] v, input int b);
    for (int p = 0; p < 8; p++)
      if (v[(b + p) % 8]) return (b + p) % 8;
    return -1;
  endfunction

  task automatic chk_all_clear(input string tag);
    chk({tag, " mask"}, mask_out, 8'h00);
    chk({tag, " base"}, vec_base, 8'h00);
    chk({tag, " flags"}, {auto_eoi, nested_sfn, rot_on_aeoi, read_insvc,
                          poll_mode, spec_mask, 2'b00}, 8'h00);
    chk({tag, " rot"}, {5'd0, rot_base}, 8'h00);
    chk({tag, " trig"}, trig_mode, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..R10 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic exp_poll, exp_rsel, exp_smm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all_clear("R1 reset");
    chk("R1 reset clr", insvc_clr | req_clr, 8'h00);

    // R10: trigger register sweep, constant keeps lines 0..2 in edge mode
    for (int v = 0; v < 256; v++) begin
      wr_trig(8'(v));
      chk("R10 trig", trig_mode, 8'(v) & 8'hF8);
    end

    // R1: start word with ignored bits 1 and 3 and mode-word bit 0
    wr_bus(1'b1, 8'h5A);
    wr_bus(1'b0, 8'h1B);
    chk("R1 init insvc pulse", insvc_clr, 8'hFF);
    chk("R1 init req pulse", req_clr, 8'hFF);
    chk_all_clear("R1 init");
    // R2: base word, cascade word (skipped), mode word
    wr_bus(1'b1, 8'hA7);
    chk("R2 vec base", vec_base, 8'hA0);
    wr_bus(1'b1, 8'h55);
    chk("R2 cascade skipped mask", mask_out, 8'h00);
    chk("R2 cascade skipped base", vec_base, 8'hA0);
    wr_bus(1'b1, 8'h12);
    chk("R2 mode word", {6'd0, nested_sfn, auto_eoi}, 8'h03);
    chk("R2 mode mask untouched", mask_out, 8'h00);
    wr_bus(1'b1, 8'h3C);
    chk("R3 mask after init", mask_out, 8'h3C);

    // R2: short sequence without the mode word
    wr_bus(1'b0, 8'h10);
    chk("R1 pulse clear next", insvc_clr, 8'hFF);
    wr_bus(1'b1, 8'h4F);
    chk("R2 short base", vec_base, 8'h48);
    wr_bus(1'b1, 8'hFF);
    chk("R2 short cascade mask", mask_out, 8'h00);
    wr_bus(1'b1, 8'h99);
    chk("R2 short mask", mask_out, 8'h99);
    chk("R2 short aeoi", {7'd0, auto_eoi}, 8'h00);

    // R3: mask sweep with readback
    for (int v = 0; v < 256; v++) begin
      wr_bus(1'b1, 8'(v));
      chk("R3 mask out", mask_out, 8'(v));
      rd_bus(1'b1, got);
      chk("R3 mask read", got, 8'(v));
    end

    // R4 / R9: read-poll command sweep over all enable/value bit combinations
    exp_poll = 0; exp_rsel = 0; exp_smm = 0;
    poll_valid = 1'b0;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      b = 5'(v);
      wr_bus(1'b0, {1'b0, b[4], b[3], 1'b0, 1'b1, b[2], b[1], b[0]});
      if (b[2]) exp_poll = 1;
      if (b[1]) exp_rsel = b[0];
      if (b[4]) exp_smm = b[3];
      chk("R4 poll flag", {7'd0, poll_mode}, {7'd0, exp_poll});
      chk("R4 read select", {7'd0, read_insvc}, {7'd0, exp_rsel});
      chk("R4 special mask", {7'd0, spec_mask}, {7'd0, exp_smm});
      if (exp_poll) begin
        rd_bus(1'b0, got);
        chk("R9 poll none", got, 8'h07);
        chk("R9 poll none no clr", insvc_clr | req_clr, 8'h00);
        chk("R9 poll cleared", {7'd0, poll_mode}, 8'h00);
        exp_poll = 0;
      end
    end

    // R9: poll reads with resolver results, at both addresses
    for (int a = 0; a < 2; a++)
      for (int l = 0; l < 8; l++) begin
        wr_bus(1'b0, 8'h0C);
        poll_valid = 1'b1; poll_line = 3'(l);
        rd_bus(1'(a), got);
        chk("R9 poll line", got, 8'(l));
        chk("R9 poll insvc clr", insvc_clr, 8'(1 << l));
        chk("R9 poll req clr", req_clr, 8'(1 << l));
        chk("R9 poll off", {7'd0, poll_mode}, 8'h00);
        poll_valid = 1'b0;
      end

    // R8: register reads at address 0
    for (int v = 0; v < 256; v += 17) begin
      insvc_vec = 8'(v); req_vec = ~8'(v);
      wr_bus(1'b0, 8'h0B);
      rd_bus(1'b0, got);
      chk("R8 read insvc", got, 8'(v));
      wr_bus(1'b0, 8'h0A);
      rd_bus(1'b0, got);
      chk("R8 read req", got, ~8'(v));
    end

    // R5: rotate-on-auto-EOI codes; R7: code 2 has no effect
    wr_bus(1'b0, 8'h80);
    chk("R5 code4", {7'd0, rot_on_aeoi}, 8'h01);
    wr_bus(1'b0, 8'hC5);
    insvc_vec = 8'hFF;
    wr_bus(1'b0, 8'h40);
    chk("R7 code2 clr", insvc_clr, 8'h00);
    chk("R7 code2 rot", {5'd0, rot_base}, 8'h06);
    chk("R7 code2 aeoi", {7'd0, rot_on_aeoi}, 8'h01);
    wr_bus(1'b0, 8'h00);
    chk("R5 code0", {7'd0, rot_on_aeoi}, 8'h00);

    // R6: non-specific end-of-interrupt across every base and in-service pattern
    for (int b = 0; b < 8; b++)
      for (int v = 0; v < 256; v++) begin
        int t;
        t = eoi_target(8'(v), b);
        wr_bus(1'b0, 8'hC0 | 8'((b + 7) % 8));
        chk("R7 code6 base", {5'd0, rot_base}, 8'(b));
        insvc_vec = 8'(v);
        wr_bus(1'b0, 8'h20);
        chk("R6 code1 clr", insvc_clr, (t < 0) ? 8'h00 : 8'(1 << t));
        chk("R6 code1 base", {5'd0, rot_base}, 8'(b));
        wr_bus(1'b0, 8'hA0);
        chk("R6 code5 clr", insvc_clr, (t < 0) ? 8'h00 : 8'(1 << t));
        chk("R6 code5 base", {5'd0, rot_base}, (t < 0) ? 8'(b) : 8'((t + 1) % 8));
      end

    // R7: specific end-of-interrupt and specific rotate
    insvc_vec = 8'h00;
    for (int l = 0; l < 8; l++) begin
      wr_bus(1'b0, 8'hC3);
      wr_bus(1'b0, 8'h60 | 8'(l));
      chk("R7 code3 clr", insvc_clr, 8'(1 << l));
      chk("R7 code3 base", {5'd0, rot_base}, 8'h04);
      wr_bus(1'b0, 8'hE0 | 8'(l));
      chk("R7 code7 clr", insvc_clr, 8'(1 << l));
      chk("R7 code7 base", {5'd0, rot_base}, 8'((l + 1) % 8));
    end

    // R1: start word clears trigger register and flags set earlier
    wr_trig(8'hFF);
    wr_bus(1'b0, 8'h0F);
    wr_bus(1'b0, 8'h1A);
    chk_all_clear("R1 reinit");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule